// File: doc/BRIEF.md
# External Bus Owner Arbiter: Processor versus DMA

This block decides who drives the one external memory bus: the processor core or the DMA channel that is currently active. Each side raises a request and supplies a priority value. The core's value comes from its status register and the DMA value comes from the active channel. A two-bit policy input chooses how contention is resolved. The policy input comes from the mode register, and that register resets to the core-first code.

Once the bus is granted, the owner keeps it for the whole access. The port raises a one-cycle completion strobe when the access finishes, and arbitration happens again in that same cycle. When the bus is idle, the block arbitrates on every cycle. Grants are registered, one-hot, and appear on the clock edge that follows the arbitration decision.

Top module: `bus_prio_arbiter`

## Requirements
- R1: After reset, both grant outputs are low.
- R2: At most one grant output is high in any cycle. A grant appears on the clock edge after the cycle in which it was decided.
- R3: At an arbitration point, a lone requester receives the grant whatever the policy code is.
- R4: At an arbitration point with neither request raised, no grant is driven in the next cycle.
- R5: While a grant is held and the completion strobe is low, the grant is kept. Request, priority and policy changes have no effect on it.
- R6: Policy code 2'b01: when both sides request at an arbitration point, DMA wins.
- R7: Policy code 2'b11: when both sides request at an arbitration point, the core wins.
- R8: Policy code 2'b10: contended grants alternate between the two sides. The first contended grant under this code after reset goes to the core. Only contended grants under this code advance the turn.
- R9: Policy code 2'b00: when both sides request, the side with the numerically higher priority value wins. Equal values go to the core.
- R10: An arbitration point is any cycle in which no grant is held, or any cycle in which the completion strobe is high. A strobe with a pending request hands the bus over on the next edge with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | 1 | Core wants the bus |
| core_prio | input | PW | Core priority from its status register |
| dma_req | input | 1 | Active DMA channel wants the bus |
| dma_prio | input | PW | Priority of the active DMA channel |
| bus_policy | input | 2 | Contention policy code (00 dynamic, 01 DMA first, 10 alternate, 11 core first) |
| access_done | input | 1 | Current access finishes in this cycle |
| core_gnt | output | 1 | Bus granted to the core |
| dma_gnt | output | 1 | Bus granted to DMA |

## Verification
Random stimulus covers every policy code together with random priorities and a completion strobe that is often low. This separates the hold-until-done behaviour from a naive arbitrate-every-cycle design. Directed cases force contention under each code. Two cases in particular tell the compare direction and the tie rule apart from each other: equal priorities under the dynamic code, and a DMA priority exactly one above the core's. A run of contended grants under the alternate code shows that the turn advances only on contention. Back-to-back handovers on the strobe show that no idle cycle is inserted.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic [1:0] {
      OWN_NONE = 2'b00,
      OWN_CORE = 2'b01,
      OWN_DMA  = 2'b10
   } owner_t;

   typedef enum logic [1:0] {
      POL_DYNAMIC   = 2'b00,
      POL_DMA_FIRST = 2'b01,
      POL_ALTERNATE = 2'b10,
      POL_CORE_FIRST= 2'b11
   } policy_t;
endpackage

// File: rtl/arb_decide.sv
module arb_decide
   import arb_pkg::*;
#(
   parameter int PW = 2
) (
   input  logic          req_core,
   input  logic          req_dma,
   input  logic [PW-1:0] prio_core,
   input  logic [PW-1:0] prio_dma,
   input  logic [1:0]    policy,
   input  logic          turn_dma,
   output owner_t        winner,
   output logic          contended
);
   generate
      if (PW < 1) begin : g_bad_pw
         $error("arb_decide: PW must be at least 1");
      end
   endgenerate

   logic dma_wins_contest;

   always_comb begin
      unique case (policy_t'(policy))
         POL_DMA_FIRST:  dma_wins_contest = 1'b1;
         POL_CORE_FIRST: dma_wins_contest = 1'b0;
         POL_ALTERNATE:  dma_wins_contest = turn_dma;
         default:        dma_wins_contest = (prio_dma > prio_core);
      endcase
   end

   always_comb begin
      contended = req_core & req_dma;
      if (contended)     winner = dma_wins_contest ? OWN_DMA : OWN_CORE;
      else if (req_core) winner = OWN_CORE;
      else if (req_dma)  winner = OWN_DMA;
      else               winner = OWN_NONE;
   end

   always_comb begin
      AST_LONE_CORE: assert (!(req_core && !req_dma) || winner == OWN_CORE); // R3
      AST_LONE_DMA:  assert (!(req_dma && !req_core) || winner == OWN_DMA);  // R3
   end
endmodule

// File: rtl/arb_turn.sv
module arb_turn (
   input  logic clk,
   input  logic rst_n,
   input  logic advance,
   input  logic core_won,
   output logic turn_dma
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       turn_dma <= 1'b0;
      else if (advance) turn_dma <= core_won;
   end

   AST_TURN_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> (turn_dma == $past(core_won))); // R8
   AST_TURN_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(turn_dma)); // R8
endmodule

// File: rtl/arb_owner.sv
module arb_owner
   import arb_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   done,
   input  owner_t winner,
   output owner_t owner,
   output logic   arb_point
);
   assign arb_point = (owner == OWN_NONE) | done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         owner <= OWN_NONE;
      else if (arb_point) owner <= winner;
   end

   AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
      (owner != OWN_NONE && !done) |=> (owner == $past(owner))); // R5
   AST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (owner == $past(winner))); // R10
endmodule

// File: rtl/bus_prio_arbiter.sv
module bus_prio_arbiter
   import arb_pkg::*;
#(
   parameter int PW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          core_req,
   input  logic [PW-1:0] core_prio,
   input  logic          dma_req,
   input  logic [PW-1:0] dma_prio,
   input  logic [1:0]    bus_policy,
   input  logic          access_done,
   output logic          core_gnt,
   output logic          dma_gnt
);
   owner_t winner, owner;
   logic   contended, turn_dma, arb_point, advance;

   arb_decide #(.PW(PW)) u_decide (
      .req_core (core_req),
      .req_dma  (dma_req),
      .prio_core(core_prio),
      .prio_dma (dma_prio),
      .policy   (bus_policy),
      .turn_dma (turn_dma),
      .winner   (winner),
      .contended(contended)
   );

   arb_owner u_owner (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (access_done),
      .winner   (winner),
      .owner    (owner),
      .arb_point(arb_point)
   );

   assign advance = arb_point & contended & (bus_policy == POL_ALTERNATE);

   arb_turn u_turn (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (advance),
      .core_won(winner == OWN_CORE),
      .turn_dma(turn_dma)
   );

   assign core_gnt = (owner == OWN_CORE);
   assign dma_gnt  = (owner == OWN_DMA);

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({core_gnt, dma_gnt})); // R2
   AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_point && !core_req && !dma_req) |=> !(core_gnt || dma_gnt)); // R4
   AST_DMA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_point && core_req && dma_req && bus_policy == 2'b01) |=> dma_gnt); // R6
   AST_CORE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_point && core_req && dma_req && bus_policy == 2'b11) |=> core_gnt); // R7
   AST_DYN_TIE: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_point && core_req && dma_req && bus_policy == 2'b00 && core_prio == dma_prio)
      |=> core_gnt); // R9
endmodule

// File: tb/sim_bus_prio_arbiter.sv
module sim_bus_prio_arbiter;
   localparam int CLK_PERIOD = 10;
   localparam int PW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic core_req = 0, dma_req = 0, access_done = 0;
   logic [PW-1:0] core_prio = '0, dma_prio = '0;
   logic [1:0] bus_policy = 2'b11;
   logic core_gnt, dma_gnt;

   int checks = 0, fails = 0;
   int exp_owner = 0;      // 0 none, 1 core, 2 dma
   bit exp_turn_dma = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_prio_arbiter #(.PW(PW)) u0 (
      .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_prio(core_prio),
      .dma_req(dma_req), .dma_prio(dma_prio), .bus_policy(bus_policy),
      .access_done(access_done), .core_gnt(core_gnt), .dma_gnt(dma_gnt));

   function automatic int pick(bit cr, bit dr, int cp, int dp, int pol, bit turn);
      if (cr && dr) begin
         case (pol)
            1: return 2;
            3: return 1;
            2: return turn ? 2 : 1;
            default: return (dp > cp) ? 2 : 1;
         endcase
      end
      if (cr) return 1;
      if (dr) return 2;
      return 0;
   endfunction

   function automatic string tag_for(bit arb, bit cr, bit dr, int pol);
      if (!arb) return "R5";
      if (cr && dr) begin
         case (pol)
            1: return "R6";
            3: return "R7";
            2: return "R8";
            default: return "R9";
         endcase
      end
      if (cr || dr) return "R3";
      return "R4";
   endfunction

   task automatic check(string tag, int exp);
      int act;
      act = {30'd0, dma_gnt, core_gnt};
      checks++;
      if (act != ((exp == 0) ? 0 : (exp == 1) ? 1 : 2)) begin
         fails++;
         $display("FAIL %s: grants {dma,core}=%0d expected %0d", tag, act,
                  (exp == 0) ? 0 : (exp == 1) ? 1 : 2);
      end
      checks++;
      if (core_gnt && dma_gnt) begin
         fails++;
         $display("FAIL R2: both grants high, actual 2'b11 expected at most one");
      end
   endtask

   task automatic step(bit cr, int cp, bit dr, int dp, int pol, bit dn, string tag);
      bit arb;
      int w;
      string t;
      @(negedge clk);
      core_req = cr; core_prio = cp[PW-1:0];
      dma_req = dr; dma_prio = dp[PW-1:0];
      bus_policy = pol[1:0]; access_done = dn;
      @(posedge clk);
      arb = (exp_owner == 0) || dn;
      t = (tag == "") ? tag_for(arb, cr, dr, pol) : tag;
      if (arb) begin
         w = pick(cr, dr, cp, dp, pol, exp_turn_dma);
         if (cr && dr && pol == 2) exp_turn_dma = (w == 1);
         exp_owner = w;
      end
      #1;
      check(t, exp_owner);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'h1f2e3d4c;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      #1;
      check("R1", 0);
      @(negedge clk); rst_n = 1'b1;

      // R8: first contention under alternate goes to the core, then alternates
      step(1,0,1,0,2,0,"R8");
      step(1,0,1,0,2,1,"R8");
      step(1,0,1,0,2,1,"R8");
      // R5: policy flip mid-access changes nothing
      step(1,0,1,3,1,0,"R5");
      step(0,0,1,3,0,0,"R5");
      // R10: back-to-back handover on the strobe
      step(0,0,1,0,3,1,"R10");
      step(1,0,0,0,3,1,"R10");
      step(0,0,0,0,3,1,"R4");
      // R9: tie goes to core, DMA one above wins
      step(1,2,1,2,0,0,"R9");
      step(1,1,1,2,0,1,"R9");
      step(1,3,1,0,0,1,"R9");
      step(0,0,0,0,0,1,"R4");
      // R6 / R7 contention
      step(1,0,1,0,1,0,"R6");
      step(1,3,1,0,3,1,"R7");
      // R3: lone requester under each code
      for (int p = 0; p < 4; p++) begin
         step(0,0,0,0,p,1,"R4");
         step(0,0,1,0,p,0,"R3");
         step(1,3,0,0,p,1,"R3");
      end
      step(0,0,0,0,3,1,"R4");

      for (int i = 0; i < 4000; i++) begin
         step($urandom_range(0,1) == 1, $urandom_range(0,3),
              $urandom_range(0,1) == 1, $urandom_range(0,3),
              $urandom_range(0,3), $urandom_range(0,3) == 0, "");
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule